// File: doc/BRIEF.md
# Serial Receiver with Two-Deep Buffer and Overrun Lockout

This block receives asynchronous serial characters of eight data bits, no parity and one stop bit. It works from a 16x oversampling tick that comes from outside the block. The serial input first passes through a synchronizer. A frame engine then finds the start bit, samples each bit at its centre and shifts the data into an internal register that the host cannot see. As soon as the stop bit has been sampled, the finished character moves into a two-entry buffer, together with a flag that tells whether its stop bit was valid.

The host sees three things: a flag that says data is waiting, the oldest byte, and the framing flag that belongs to that byte. A one-cycle read strobe removes the oldest entry. A character may finish while both entries are still occupied. In that case the character is thrown away, a sticky overrun flag is raised, and the receiver stops accepting characters. Draining the buffer does not end this state. Only a one-cycle clear pulse ends it. The clear pulse returns the frame engine to idle and leaves the buffered bytes in place.

Top module: `rx_lockout_uart`

## Requirements
- R1: After reset, `data_avail` and `ovr_flag` are both 0.
- R2: A valid frame sets `data_avail`. Its eight data bits are sampled at mid-bit, least significant bit first, and are presented on `head_data`. The frame is a low start bit, eight data bits and a stop bit, each lasting 16 oversample ticks.
- R3: The buffer holds at most two characters. `head_data` always shows the oldest one, and a `rd_pop` pulse moves the head to the next one.
- R4: When a character completes while both entries are full and no pop occurs in that cycle, the character is discarded, `ovr_flag` goes to 1, and the buffered bytes do not change.
- R5: While `ovr_flag` is 1, no new character enters the buffer, even after the host has emptied it.
- R6: A pulse on `ovr_clear` sets `ovr_flag` to 0 and reception starts again. Bytes already in the buffer are kept.
- R7: `head_ferr` is 1 when the stop-bit sample of the head byte was 0. The flag is stored per byte and changes when the head is popped.
- R8: After a framing error the receiver keeps running, and the next character is received correctly with `head_ferr` at 0.
- R9: A low pulse on the line that has ended before the mid-bit start sample (sample 8 of 16) is ignored as a glitch and produces no character.
- R10: A `rd_pop` while the buffer is empty has no effect. `data_avail` stays at 0.
- R11: When a pop and a completing character fall in the same cycle while the buffer is full, no overrun occurs and the new character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rd_pop | input | 1 | Removes the oldest buffered byte |
| ovr_clear | input | 1 | Clears the overrun lockout |
| data_avail | output | 1 | At least one byte is buffered |
| head_data | output | 8 | Oldest buffered byte |
| head_ferr | output | 1 | Framing-error flag of the oldest byte |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The assertions check on every cycle that the buffer occupancy stays within two and changes by at most one, that an overrun is raised only by a completing character meeting a full buffer with no pop, that nothing completes while locked, that the overrun flag holds until cleared, and that a pop coinciding with completion on a full buffer never locks. Byte values, bit order, per-byte framing flags, glitch rejection and preservation of the buffer across a clear are visible only through the bench's frame scenarios. The bench compares these against a queue model it keeps itself.

// File: rtl/rxl_pkg.sv
package rxl_pkg;

    // Frame engine phases
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_e;

    parameter int unsigned RXL_DATA_W = 8;
    parameter int unsigned RXL_OSR    = 16;
    parameter int unsigned RXL_DEPTH  = 2;
    parameter int unsigned RXL_SYNC   = 2;

endpackage

// File: rtl/rxl_sync.sv
module rxl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rxl_frame.sv
module rxl_frame
    import rxl_pkg::*;
#(
    parameter int unsigned DATA_W = RXL_DATA_W,
    parameter int unsigned OSR    = RXL_OSR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic              tick,
    input  logic              halt,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ferr
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

    typedef struct packed {
        fr_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              prev;
        logic              done;
        logic              ferr;
    } fr_regs_t;

    fr_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (halt) begin
            r_d.st   = FR_IDLE;
            r_d.cnt  = '0;
            r_d.prev = rx_s;
        end else if (tick) begin
            r_d.prev = rx_s;
            unique case (r_q.st)
                FR_IDLE: begin
                    if (r_q.prev && !rx_s) begin
                        r_d.st  = FR_START;
                        r_d.cnt = '0;
                    end
                end
                FR_START: begin
                    if (r_q.cnt == MID) begin
                        r_d.cnt = '0;
                        r_d.idx = '0;
                        r_d.st  = rx_s ? FR_IDLE : FR_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                FR_DATA: begin
                    if (r_q.cnt == LAST) begin
                        r_d.cnt = '0;
                        r_d.sh  = {rx_s, r_q.sh[DATA_W-1:1]};
                        if (r_q.idx == TOP) r_d.st  = FR_STOP;
                        else                r_d.idx = r_q.idx + 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                FR_STOP: begin
                    if (r_q.cnt == LAST) begin
                        r_d.cnt  = '0;
                        r_d.done = 1'b1;
                        r_d.ferr = !rx_s;
                        r_d.st   = FR_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: r_d.st = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= FR_IDLE;
            r_q.prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign done = r_q.done;
    assign data = r_q.sh;
    assign ferr = r_q.ferr;
endmodule

// File: rtl/rxl_fifo.sv
module rxl_fifo
    import rxl_pkg::*;
#(
    parameter int unsigned DATA_W = RXL_DATA_W,
    parameter int unsigned DEPTH  = RXL_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         wferr,
    input  logic                         pop,
    output logic [DATA_W-1:0]            head_data,
    output logic                         head_ferr,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         drop
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic              ferr;
        logic [DATA_W-1:0] data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0]  mem;
        logic [PTR_W-1:0]  rd;
        logic [PTR_W-1:0]  wr;
        logic [OCC_W-1:0]  occ;
    } fifo_regs_t;

    fifo_regs_t f_d, f_q;
    logic pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d     = f_q;
        pop_ok  = pop && (f_q.occ != '0);
        push_ok = push && ((f_q.occ != FULL_OCC) || pop_ok);
        drop    = push && !push_ok;
        if (push_ok) begin
            f_d.mem[f_q.wr] = '{ferr: wferr, data: wdata};
            f_d.wr          = step(f_q.wr);
        end
        if (pop_ok) begin
            f_d.rd = step(f_q.rd);
        end
        f_d.occ = f_q.occ + OCC_W'(push_ok) - OCC_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_data = f_q.mem[f_q.rd].data;
    assign head_ferr = f_q.mem[f_q.rd].ferr;
    assign occ       = f_q.occ;
endmodule

// File: rtl/rx_lockout_uart.sv
module rx_lockout_uart
    import rxl_pkg::*;
#(
    parameter int unsigned DATA_W = RXL_DATA_W,
    parameter int unsigned OSR    = RXL_OSR,
    parameter int unsigned DEPTH  = RXL_DEPTH,
    parameter int unsigned SYNC   = RXL_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              rd_pop,
    input  logic              ovr_clear,
    output logic              data_avail,
    output logic [DATA_W-1:0] head_data,
    output logic              head_ferr,
    output logic              ovr_flag
);
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);

    logic              rx_s;
    logic              frame_done;
    logic [DATA_W-1:0] frame_data;
    logic              frame_ferr;
    logic              fifo_drop;
    logic [OCC_W-1:0]  fifo_occ;
    logic              ovr_d, ovr_q;

    rxl_sync #(.STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    rxl_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk  (clk),
        .rst_n(rst_n),
        .rx_s (rx_s),
        .tick (os_tick),
        .halt (ovr_q | ovr_clear),
        .done (frame_done),
        .data (frame_data),
        .ferr (frame_ferr)
    );

    rxl_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (frame_done && !ovr_q),
        .wdata    (frame_data),
        .wferr    (frame_ferr),
        .pop      (rd_pop),
        .head_data(head_data),
        .head_ferr(head_ferr),
        .occ      (fifo_occ),
        .drop     (fifo_drop)
    );

    always_comb begin
        ovr_d = ovr_q;
        if (ovr_clear)      ovr_d = 1'b0;
        else if (fifo_drop) ovr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    assign ovr_flag   = ovr_q;
    assign data_avail = (fifo_occ != '0);
endmodule

// File: rtl/rxl_checker.sv
module rxl_checker #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned OCC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_pop,
    input logic             ovr_clear,
    input logic             ovr_flag,
    input logic             data_avail,
    input logic [OCC_W-1:0] occ,
    input logic             done
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!data_avail && !ovr_flag));

    a_r2_avail_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_avail) |-> $past(done));

    a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

    a_r3_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, occ} <= {1'b0, $past(occ)} + 1'b1) &&
        ({1'b0, occ} + 1'b1 >= {1'b0, $past(occ)}));

    a_r4_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($past(occ) == OCC_W'(DEPTH) && $past(done) && !$past(rd_pop)));

    a_r5_no_completion_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovr_flag) |-> !done);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clear) |=> ovr_flag);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clear |=> !ovr_flag);

    a_r11_pop_push_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(DEPTH) && rd_pop && done && !ovr_flag) |=> !ovr_flag);
endmodule

bind rx_lockout_uart rxl_checker #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pop    (rd_pop),
    .ovr_clear (ovr_clear),
    .ovr_flag  (ovr_flag),
    .data_avail(data_avail),
    .occ       (fifo_occ),
    .done      (frame_done)
);

// File: tb/sim_rx_lockout_uart.sv
`timescale 1ns/1ps
module sim_rx_lockout_uart;
    localparam int TICK_DIV  = 4;
    localparam int OSR       = 16;
    localparam int BIT_CYC   = OSR * TICK_DIV;
    localparam int FRAME_CYC = 10 * BIT_CYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       rd_pop = 1'b0;
    logic       ovr_clear = 1'b0;
    logic       data_avail;
    logic [7:0] head_data;
    logic       head_ferr;
    logic       ovr_flag;

    int total = 0;
    int bad = 0;
    int phase = 0;
    int lat = 0;
    logic [8:0] mq[$];
    bit m_ovr = 1'b0;

    rx_lockout_uart u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .rd_pop(rd_pop), .ovr_clear(ovr_clear), .data_avail(data_avail),
        .head_data(head_data), .head_ferr(head_ferr), .ovr_flag(ovr_flag)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            phase   = (phase == TICK_DIV - 1) ? 0 : phase + 1;
            os_tick = (phase == 0);
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // Compare the ports against the bench model
    task automatic chk_model(input string req);
        chk(req, int'(data_avail), int'(mq.size() != 0));
        chk(req, int'(ovr_flag), int'(m_ovr));
        if (mq.size() != 0) begin
            chk(req, int'(head_data), int'(mq[0][7:0]));
            chk(req, int'(head_ferr), int'(mq[0][8]));
        end
    endtask

    function automatic void model_frame(input logic [7:0] d, input bit stop_ok, input bit popped);
        if (popped && mq.size() != 0) void'(mq.pop_front());
        if (m_ovr) return;
        if (mq.size() >= 2) m_ovr = 1'b1;
        else mq.push_back({!stop_ok, d});
    endfunction

    // Drives one frame; measure=1 records latency, pop_at=1 pops at lat-1
    task automatic send_frame(input logic [7:0] d, input bit stop_ok,
                              input bit measure, input bit pop_at);
        bit seen = 1'b0;
        do begin @(negedge clk); #1; end while (phase != 1);
        for (int n = 0; n < FRAME_CYC; n++) begin
            int b = n / BIT_CYC;
            if (measure && !seen && data_avail) begin lat = n; seen = 1'b1; end
            if (b == 0)      rx_line = 1'b0;
            else if (b <= 8) rx_line = d[b-1];
            else             rx_line = stop_ok;
            if (pop_at) rd_pop = (n == lat - 1);
            @(negedge clk);
        end
        rd_pop  = 1'b0;
        rx_line = 1'b1;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] d, input bit stop_ok, input string req);
        send_frame(d, stop_ok, 1'b0, 1'b0);
        model_frame(d, stop_ok, 1'b0);
        chk_model(req);
    endtask

    task automatic pop(input string req);
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
        if (mq.size() != 0) void'(mq.pop_front());
        chk_model(req);
    endtask

    task automatic clear(input string req);
        @(negedge clk); ovr_clear = 1'b1;
        @(negedge clk); ovr_clear = 1'b0;
        m_ovr = 1'b0;
        chk_model(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 avail", int'(data_avail), 0);
        chk("R1 ovr", int'(ovr_flag), 0);

        // R10 pop on empty
        pop("R10 pop empty");
        chk("R10 avail", int'(data_avail), 0);

        // R2 first frame, latency measured
        send_frame(8'hA5, 1'b1, 1'b1, 1'b0);
        model_frame(8'hA5, 1'b1, 1'b0);
        chk("R2 head", int'(head_data), 'hA5);
        chk("R2 avail", int'(data_avail), 1);
        chk_model("R2");

        // R3 ordering
        frame(8'h3C, 1'b1, "R3 second");
        chk("R3 head oldest", int'(head_data), 'hA5);
        pop("R3 pop1");
        chk("R3 head next", int'(head_data), 'h3C);
        pop("R3 pop2");

        // R7 / R8 framing error travels with its byte
        frame(8'h11, 1'b0, "R7 bad stop");
        frame(8'h22, 1'b1, "R8 next ok");
        chk("R7 ferr head", int'(head_ferr), 1);
        pop("R7 pop");
        chk("R8 data", int'(head_data), 'h22);
        chk("R8 ferr", int'(head_ferr), 0);
        pop("R8 drain");

        // R9 glitch shorter than mid-bit
        do begin @(negedge clk); #1; end while (phase != 1);
        rx_line = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (FRAME_CYC) @(negedge clk);
        chk("R9 no char", int'(data_avail), 0);

        // R4 / R5 / R6 overrun lockout
        frame(8'h01, 1'b1, "R4 fill1");
        frame(8'h02, 1'b1, "R4 fill2");
        frame(8'h03, 1'b1, "R4 third");
        chk("R4 ovr", int'(ovr_flag), 1);
        chk("R4 head kept", int'(head_data), 'h01);
        pop("R5 pop");
        frame(8'h04, 1'b1, "R5 locked");
        chk("R5 head", int'(head_data), 'h02);
        pop("R5 drain");
        frame(8'h06, 1'b1, "R5 locked empty");
        chk("R5 still empty", int'(data_avail), 0);
        frame(8'h07, 1'b1, "R6 prep");
        clear("R6 clear empty");
        frame(8'h08, 1'b1, "R6 fill");
        frame(8'h09, 1'b1, "R6 fill2");
        frame(8'h0A, 1'b1, "R6 ovr again");
        clear("R6 clear keeps");
        chk("R6 ovr off", int'(ovr_flag), 0);
        chk("R6 head kept", int'(head_data), 'h08);
        pop("R6 pop");
        frame(8'h0B, 1'b1, "R6 resumed");
        pop("R6 pop2");
        chk("R6 new byte", int'(head_data), 'h0B);
        pop("R6 drain");

        // R11 pop coinciding with completion on a full buffer
        frame(8'h10, 1'b1, "R11 fill1");
        frame(8'h20, 1'b1, "R11 fill2");
        send_frame(8'h30, 1'b1, 1'b0, 1'b1);
        model_frame(8'h30, 1'b1, 1'b1);
        chk("R11 no ovr", int'(ovr_flag), 0);
        chk("R11 head", int'(head_data), 'h20);
        chk_model("R11");
        pop("R11 pop");
        chk("R11 new", int'(head_data), 'h30);
        pop("R11 drain");

        // Random traffic against the model (R2 R3 R4 R5 R6 R7 R8)
        void'($urandom(32'd1234));
        for (int i = 0; i < 60; i++) begin
            logic [7:0] d = 8'($urandom);
            bit ok = ($urandom % 5) != 0;
            int npop = $urandom % 3;
            frame(d, ok, "R2 rand frame");
            for (int k = 0; k < npop; k++) pop("R3 rand pop");
            if (m_ovr && ($urandom % 2) == 0) clear("R6 rand clear");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule